// File: doc/BRIEF.md
# Receive Sample Tap Sweep Engine

This engine automates the search for a good receive-sampling delay on a high-speed eMMC link. After a start pulse it walks a tap index upward from zero. Each tap is written to the PHY through two self-clearing update strobes. After that, an external agent is asked to run one tuning-block transfer and report whether the data came back correctly.

While sweeping, the engine keeps the length of the current run of consecutive good taps. It also keeps the longest run seen so far, together with the position just past that run's last tap. When the sweep is over it sets the tap to the middle of the longest run and applies that tap with the same double update. It then pulses `done_o`. If no tap passed, or if the final update times out, it pulses `err_o` together with `done_o`.

The engine is built around one controller state machine. Its states are:

- `ST_IDLE`: waits for start.
- `ST_APPLY`: launches the double update for the current tap.
- `ST_WAIT_UPD`: waits for the update to finish.
- `ST_PROBE`: requests the transfer.
- `ST_WAIT_XFER`: waits for the transfer result.
- `ST_SCORE`: feeds the result to the run tracker and moves to the next tap.
- `ST_DECIDE`: picks the centre tap or flags an error.
- `ST_COMMIT` and `ST_WAIT_COMMIT`: apply the chosen tap.
- `ST_FINISH`: pulses done.

Its transitions are:

- IDLE to APPLY on start.
- APPLY to WAIT_UPD.
- WAIT_UPD to PROBE on update success, or to SCORE on update timeout.
- PROBE to WAIT_XFER.
- WAIT_XFER to SCORE on transfer done.
- SCORE back to APPLY, or to DECIDE after the last tap.
- DECIDE to COMMIT, or to FINISH when nothing passed.
- COMMIT to WAIT_COMMIT.
- WAIT_COMMIT to FINISH.
- FINISH to IDLE.

A small update sequencer has its own states: `US_IDLE`, `US_STROBE` and `US_WAIT`. It issues the strobes and polls the busy return.

Top module: `tap_sweep_engine`

## Requirements
- R1: After reset, `done_o`, `err_o`, `upd_strobe_o` and `xfer_req_o` are low and `tap_o` is 0.
- R2: A sweep presents taps 0 to NUM_TAPS-1 (0 to 39 by default) in ascending order. The transfers are requested in that order, at most one per tap, and `tap_o` holds steady while an update is in flight.
- R3: Every tap change issues exactly two update strobes, each one cycle long. The second strobe comes only after busy has been seen low following the first. A transfer is requested only after both strobes have completed.
- R4: An update whose busy return is sampled high for UPD_TIMEOUT consecutive cycles (8 in the bench) after a strobe counts as a failed tap, and no transfer is requested for that tap. Busy held for UPD_TIMEOUT-1 samples still succeeds.
- R5: A tap whose transfer reports fail (`xfer_pass_i` low while `xfer_done_i` is high) is bad, and it ends the current run of good taps.
- R6: The best run is replaced only when the current run becomes strictly longer than it, so of two equal runs the earlier one is kept.
- R7: The chosen tap equals E minus floor(L/2). Here L is the best run length and E is one past the last good tap of that run.
- R8: The chosen tap is applied with two update strobes before `done_o` rises. `done_o` is high for exactly one cycle per sweep.
- R9: If no tap passed, `done_o` and `err_o` pulse together and no final update strobe is issued.
- R10: If the final update times out, `err_o` pulses together with `done_o`.
- R11: A start pulse while a sweep is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a sweep (one-cycle pulse, ignored when not idle) |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |
| err_o | output | 1 | High with done_o when no tap was found or the final update failed |
| tap_o | output | TAP_W | Tap value driven to the PHY |
| upd_strobe_o | output | 1 | One-cycle request to load tap_o into the PHY |
| upd_busy_i | input | 1 | PHY update still in progress |
| xfer_req_o | output | 1 | One-cycle request to run a tuning transfer |
| xfer_done_i | input | 1 | Transfer finished (one-cycle pulse) |
| xfer_pass_i | input | 1 | Transfer result, valid with xfer_done_i |

## Verification
Two events can land in the same cycle in the update sequencer: the busy return falling, and the timeout counter reaching its limit. The bench places them side by side by making its PHY model hold busy for exactly one sample fewer than the limit, and then for exactly the limit. The first case must give a normal tap choice with no error. The second must fail every tap and report an error with no transfer ever requested. A second overlap is a start pulse arriving in the middle of a sweep. It is judged by counting that exactly one done pulse appears and that the chosen tap is unchanged.

// File: rtl/tap_sweep_pkg.sv
package tap_sweep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_APPLY,
        ST_WAIT_UPD,
        ST_PROBE,
        ST_WAIT_XFER,
        ST_SCORE,
        ST_DECIDE,
        ST_COMMIT,
        ST_WAIT_COMMIT,
        ST_FINISH
    } eng_state_e;

    typedef enum logic [1:0] {
        US_IDLE,
        US_STROBE,
        US_WAIT
    } upd_state_e;

endpackage

// File: rtl/tap_update_seq.sv
module tap_update_seq
    import tap_sweep_pkg::*;
#(
    parameter int REPEATS = 2,
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic busy_i,
    output logic strobe_o,
    output logic ok_o,
    output logic fail_o,
    output logic active_o
);

    localparam int REP_W = $clog2(REPEATS + 1);
    localparam int TMO_W = $clog2(TIMEOUT + 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

    upd_state_e       state_q, state_d;
    logic [REP_W-1:0] rep_q;
    logic [TMO_W-1:0] tmo_q;

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= US_IDLE;
            rep_q   <= '0;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                US_IDLE:   if (go_i) rep_q <= '0;
                US_STROBE: tmo_q <= '0;
                US_WAIT: begin
                    if (!busy_i) rep_q <= rep_q + 1'b1;
                    else         tmo_q <= tmo_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            US_IDLE:   if (go_i) state_d = US_STROBE;
            US_STROBE: state_d = US_WAIT;
            US_WAIT: begin
                if (!busy_i)
                    state_d = (rep_q == REP_LAST) ? US_IDLE : US_STROBE;
                else if (tmo_q == TMO_LAST)
                    state_d = US_IDLE;
            end
            default: state_d = US_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        strobe_o = (state_q == US_STROBE);
        ok_o     = (state_q == US_WAIT) && !busy_i && (rep_q == REP_LAST);
        fail_o   = (state_q == US_WAIT) && busy_i && (tmo_q == TMO_LAST);
        active_o = (state_q != US_IDLE);
    end

    // R3: strobe is a single cycle wide
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R3: a following strobe needs busy seen low in the wait state
    a_r3_strobe_after_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == US_WAIT && busy_i) |=> !strobe_o);

    // R4: timeout counter never passes its limit
    a_r4_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == US_WAIT) |-> (tmo_q <= TMO_LAST));

    // R4: success and failure never reported together
    a_r4_ok_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && fail_o));

endmodule

// File: rtl/streak_tracker.sv
module streak_tracker #(
    parameter int TAP_W    = 6,
    parameter int NUM_TAPS = 40
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr_i,
    input  logic                                 score_i,
    input  logic                                 pass_i,
    input  logic [TAP_W-1:0]                     idx_i,
    output logic [$clog2(NUM_TAPS+1)-1:0]        best_len_o,
    output logic [$clog2(NUM_TAPS+1)-1:0]        centre_o
);

    localparam int LEN_W = $clog2(NUM_TAPS + 1);

    logic [LEN_W-1:0] cur_q, best_q, end_q;
    logic [LEN_W-1:0] cur_inc;

    assign cur_inc = cur_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (clr_i) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (score_i) begin
            if (pass_i) begin
                cur_q <= cur_inc;
                if (cur_inc > best_q) begin
                    best_q <= cur_inc;
                    end_q  <= LEN_W'(idx_i) + 1'b1;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

    assign best_len_o = best_q;
    assign centre_o   = end_q - (best_q >> 1);

    // R6: best length only grows within a sweep
    a_r6_best_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> best_q >= $past(best_q));

    // R6: current run never longer than recorded best
    a_r6_cur_within_best: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= best_q);

    // R5: a failed score clears the run
    a_r5_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (score_i && !pass_i && !clr_i) |=> cur_q == '0);

endmodule

// File: rtl/tap_sweep_engine.sv
module tap_sweep_engine
    import tap_sweep_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int NUM_TAPS    = 40,
    parameter int UPD_REPEATS = 2,
    parameter int UPD_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             done_o,
    output logic             err_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             upd_strobe_o,
    input  logic             upd_busy_i,
    output logic             xfer_req_o,
    input  logic             xfer_done_i,
    input  logic             xfer_pass_i
);

    localparam int LEN_W = $clog2(NUM_TAPS + 1);
    localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(NUM_TAPS - 1);

    eng_state_e       state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic             good_q;
    logic             err_q;

    logic             seq_go, seq_ok, seq_fail, seq_active;
    logic             trk_clr, trk_score;
    logic [LEN_W-1:0] best_len, centre;

    tap_update_seq #(
        .REPEATS (UPD_REPEATS),
        .TIMEOUT (UPD_TIMEOUT)
    ) u_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (seq_go),
        .busy_i   (upd_busy_i),
        .strobe_o (upd_strobe_o),
        .ok_o     (seq_ok),
        .fail_o   (seq_fail),
        .active_o (seq_active)
    );

    streak_tracker #(
        .TAP_W    (TAP_W),
        .NUM_TAPS (NUM_TAPS)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (trk_clr),
        .score_i    (trk_score),
        .pass_i     (good_q),
        .idx_i      (tap_q),
        .best_len_o (best_len),
        .centre_o   (centre)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            good_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    tap_q <= '0;
                    err_q <= 1'b0;
                end
                ST_WAIT_UPD:    if (seq_fail) good_q <= 1'b0;
                ST_WAIT_XFER:   if (xfer_done_i) good_q <= xfer_pass_i;
                ST_SCORE:       if (tap_q != TAP_LAST) tap_q <= tap_q + 1'b1;
                ST_DECIDE: begin
                    if (best_len == '0) err_q <= 1'b1;
                    else                tap_q <= centre[TAP_W-1:0];
                end
                ST_WAIT_COMMIT: if (seq_fail) err_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i) state_d = ST_APPLY;
            ST_APPLY:       state_d = ST_WAIT_UPD;
            ST_WAIT_UPD: begin
                if (seq_ok)        state_d = ST_PROBE;
                else if (seq_fail) state_d = ST_SCORE;
            end
            ST_PROBE:       state_d = ST_WAIT_XFER;
            ST_WAIT_XFER:   if (xfer_done_i) state_d = ST_SCORE;
            ST_SCORE:       state_d = (tap_q == TAP_LAST) ? ST_DECIDE : ST_APPLY;
            ST_DECIDE:      state_d = (best_len == '0) ? ST_FINISH : ST_COMMIT;
            ST_COMMIT:      state_d = ST_WAIT_COMMIT;
            ST_WAIT_COMMIT: if (seq_ok || seq_fail) state_d = ST_FINISH;
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        seq_go     = (state_q == ST_APPLY) || (state_q == ST_COMMIT);
        xfer_req_o = (state_q == ST_PROBE);
        trk_clr    = (state_q == ST_IDLE) && start_i;
        trk_score  = (state_q == ST_SCORE);
        done_o     = (state_q == ST_FINISH);
        err_o      = (state_q == ST_FINISH) && err_q;
        tap_o      = tap_q;
    end

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: error only reported alongside done
    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R3: transfer never requested while the update sequencer runs
    a_r3_no_xfer_during_upd: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> !seq_active);

    // R2: tap held steady for the whole update
    a_r2_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && $past(seq_active)) |-> $stable(tap_o));

    // R2: tap stays within the swept range
    a_r2_tap_range: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o <= TAP_LAST);

    // R9: empty sweep ends in an error with no final update
    a_r9_empty_to_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && best_len == '0) |=> (err_o && !seq_active));

endmodule

// File: tb/tap_sweep_engine_tb.sv
`timescale 1ns/1ps
module tap_sweep_engine_tb;

    localparam int TAP_W = 6;
    localparam int NT    = 40;
    localparam int TMO   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             done_o, err_o;
    logic [TAP_W-1:0] tap_o;
    logic             upd_strobe_o;
    logic             upd_busy_i;
    logic             xfer_req_o;
    logic             xfer_done_i = 1'b0;
    logic             xfer_pass_i = 1'b0;

    always #2.5 clk = ~clk;

    tap_sweep_engine #(
        .TAP_W       (TAP_W),
        .NUM_TAPS    (NT),
        .UPD_REPEATS (2),
        .UPD_TIMEOUT (TMO)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .done_o       (done_o),
        .err_o        (err_o),
        .tap_o        (tap_o),
        .upd_strobe_o (upd_strobe_o),
        .upd_busy_i   (upd_busy_i),
        .xfer_req_o   (xfer_req_o),
        .xfer_done_i  (xfer_done_i),
        .xfer_pass_i  (xfer_pass_i)
    );

    int checks = 0;
    int fails  = 0;

    // scenario configuration (written only by the stimulus process)
    logic [NT-1:0] pass_map  = '0;
    logic [NT-1:0] stuck_map = '0;
    bit            stuck_final = 1'b0;
    int            busy_lat = 2;
    bit            mon_clr = 1'b0;

    // monitor state (written only by the monitor process)
    int busy_cnt = 0;
    int xcnt = 0;
    logic [TAP_W-1:0] xtap = '0;
    int strobes = 0;
    int xreqs = 0;
    int dones = 0;
    int order_err = 0;
    int viol = 0;
    int spt [64];
    int xlog [64];

    assign upd_busy_i = (busy_cnt != 0);

    // PHY, transfer agent and monitors, all at the falling edge
    always @(negedge clk) begin
        xfer_done_i <= 1'b0;
        if (mon_clr) begin
            strobes = 0; xreqs = 0; dones = 0; order_err = 0; viol = 0;
            for (int i = 0; i < 64; i++) begin spt[i] = 0; xlog[i] = -1; end
        end
        if (done_o) dones = dones + 1;
        if (upd_strobe_o) begin
            if (busy_cnt != 0) viol = viol + 1;
            spt[tap_o] = spt[tap_o] + 1;
            strobes = strobes + 1;
            if (stuck_final ? (strobes > 2*NT) : stuck_map[tap_o])
                busy_cnt = 1000;
            else
                busy_cnt = busy_lat + 1;
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
        end
        if (xfer_req_o) begin
            if (xreqs > 0 && int'(tap_o) <= xlog[xreqs-1]) order_err = order_err + 1;
            xlog[xreqs] = int'(tap_o);
            xreqs = xreqs + 1;
            xtap = tap_o;
            xcnt = 2;
        end else if (xcnt > 0) begin
            xcnt = xcnt - 1;
            if (xcnt == 0) begin
                xfer_done_i <= 1'b1;
                xfer_pass_i <= pass_map[xtap];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic set_win(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) pass_map[i] = 1'b1;
    endtask

    // runs one sweep; result tap/err captured on the done cycle
    task automatic run_sweep(output int tap, output int err, input int mid_start);
        int n = 0;
        bit seen = 0;
        clear_mon();
        @(negedge clk); #1 start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        tap = -1; err = -1;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if (n == mid_start) begin #1 start_i = 1'b1; @(negedge clk); #1 start_i = 1'b0; end
            if (done_o && !seen) begin
                tap = int'(tap_o); err = int'(err_o); seen = 1;
            end
            if (seen && n > 0 && !done_o && !upd_busy_i) break;
        end
        if (!seen) chk("R8", 0, 1, "sweep timed out");
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", done_o, 0, "done after reset");
        chk("R1", err_o, 0, "err after reset");
        chk("R1", upd_strobe_o, 0, "strobe after reset");
        chk("R1", xfer_req_o, 0, "xfer req after reset");
        chk("R1", tap_o, 0, "tap after reset");
    endtask

    task automatic t_all_pass();
        int tap, err, bad;
        pass_map = '1; stuck_map = '0; busy_lat = 2;
        run_sweep(tap, err, 0);
        chk("R7", tap, 20, "all-pass centre");
        chk("R8", err, 0, "all-pass err");
        chk("R8", dones, 1, "done pulse count");
        chk("R2", xreqs, NT, "transfer count");
        chk("R2", order_err, 0, "ascending order");
        bad = 0;
        for (int i = 0; i < NT; i++) if (xlog[i] != i) bad++;
        chk("R2", bad, 0, "taps in sequence");
        bad = 0;
        for (int i = 0; i < NT; i++) if (spt[i] != ((i == 20) ? 4 : 2)) bad++;
        chk("R3", bad, 0, "two strobes per tap, two more for final");
        chk("R3", viol, 0, "strobe while busy");
    endtask

    task automatic t_window(input int lo, input int hi, input int exp_tap, input string req);
        int tap, err;
        pass_map = '0; set_win(lo, hi);
        run_sweep(tap, err, 0);
        chk(req, tap, exp_tap, "centre of window");
        chk(req, err, 0, "window err");
    endtask

    task automatic t_two_windows(input int a0, input int a1, input int b0, input int b1,
                                 input int exp_tap);
        int tap, err;
        pass_map = '0; set_win(a0, a1); set_win(b0, b1);
        run_sweep(tap, err, 0);
        chk("R6", tap, exp_tap, "best of two windows");
    endtask

    task automatic t_none();
        int tap, err;
        pass_map = '0;
        run_sweep(tap, err, 0);
        chk("R9", err, 1, "no pass err");
        chk("R9", strobes, 2*NT, "no final strobes");
        chk("R9", dones, 1, "done with err");
    endtask

    task automatic t_stuck_tap();
        int tap, err;
        pass_map = '1; stuck_map = '0; stuck_map[20] = 1'b1;
        run_sweep(tap, err, 0);
        chk("R4", tap, 10, "stuck tap splits window");
        chk("R4", xreqs, NT-1, "no transfer on stuck tap");
        chk("R4", spt[20], 1, "stuck tap gets one strobe");
        stuck_map = '0;
    endtask

    task automatic t_tmo_edge();
        int tap, err;
        pass_map = '1;
        busy_lat = TMO - 1;
        run_sweep(tap, err, 0);
        chk("R4", tap, 20, "busy one below limit");
        chk("R4", err, 0, "busy one below limit err");
        busy_lat = TMO;
        run_sweep(tap, err, 0);
        chk("R4", err, 1, "busy at limit err");
        chk("R4", xreqs, 0, "busy at limit no transfer");
        busy_lat = 2;
    endtask

    task automatic t_final_tmo();
        int tap, err;
        pass_map = '0; set_win(8, 12); stuck_final = 1'b1;
        run_sweep(tap, err, 0);
        chk("R10", err, 1, "final update timeout err");
        chk("R10", strobes, 2*NT + 1, "single final strobe");
        stuck_final = 1'b0;
    endtask

    task automatic t_mid_start();
        int tap, err;
        pass_map = '0; set_win(5, 9);
        run_sweep(tap, err, 300);
        chk("R11", dones, 1, "one done despite extra start");
        chk("R11", tap, 8, "tap unchanged by extra start");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_all_pass();
        t_window(10, 17, 14, "R5");
        t_window(5, 9, 8, "R7");
        t_window(35, 39, 38, "R7");
        t_two_windows(3, 6, 20, 23, 5);
        t_two_windows(2, 4, 30, 35, 33);
        t_none();
        t_stuck_tap();
        t_tmo_edge();
        t_final_tmo();
        t_mid_start();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule